// File: doc/BRIEF.md
# Centrifuge Global Address Translator

This block turns a remote-access request into the two items the network needs: a physical routing tag that picks the destination node, and a global virtual address that the destination translates further. A request carries a register pointer and an address index. The pointer selects a stored pair of values, a mask and a base. The mask splits the index in a "centrifuge" step. Index bits at mask ones are gathered into a virtual PE number. Index bits at mask zeros are compacted into an address offset. A system can therefore interleave node bits anywhere inside the index, where a fixed split would force them into the high bits.

The offset is added to the base. The high part of the sum is a virtual segment, which a small associative segment table maps to a global segment and a base PE. The base PE and the virtual PE add up to a logical PE, and a direct-mapped table turns that into a routing tag. A shared write port programs all of the tables. The datapath is a four-stage pipeline with valid/ready flow control at both ends, and it accepts one request per cycle while the output is being drained.

Top module: `centrifuge_xlate`

## Requirements
- R1: The virtual PE number is formed by taking the index bits whose mask bit is 1, in ascending bit order, and placing them at bit 0 upward. Only the low PE_W bits of that packed value are kept.
- R2: The offset is formed by taking the index bits whose mask bit is 0, in ascending bit order, and placing them at bit 0 upward, with zeros above them.
- R3: The sum is base + offset modulo 2^IDX_W. The virtual segment is sum[IDX_W-1:OFF_W]. The segment offset is sum[OFF_W-1:0] and appears as outGva[OFF_W-1:0].
- R4: A segment entry hits when its valid bit is set and its stored virtual segment equals the request's. If several entries hit, the lowest-numbered one wins. Its global segment appears as outGva[GSEG_W+OFF_W-1:OFF_W].
- R5: When no entry hits, outMiss is 1, outTag is 0 and the global segment field of outGva is 0. The segment offset is still delivered.
- R6: On a hit, the logical PE is (entry base PE + virtual PE) modulo 2^PE_W, and outTag is the PE table word at that index.
- R7: A write happens on a clock edge where wrEn=1. The value of wrSel picks the target:
  - 0 writes the mask at pointer wrAddr.
  - 1 writes the base at pointer wrAddr.
  - 2 writes segment entry wrAddr[2:0] with the fields base PE = wrData[5:0], global segment = wrData[11:6], virtual segment = wrData[29:12] and valid = wrData[30].
  - 3 writes the PE table word at wrAddr[5:0] with tag = wrData[11:0].
- R8: A request accepted at a clock edge appears on the output after the 4th edge counted from that one. While outReady stays 1, inReady stays 1 and back-to-back requests produce results on consecutive cycles.
- R9: While outValid=1 and outReady=0, the output data is held unchanged. At most four requests are absorbed. Results leave in acceptance order, with none lost or repeated.
- R10: After reset, outValid is 0, inReady is 1 and every segment entry is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request present |
| inReady | output | 1 | Request accepted on this edge when inValid is set |
| inPtr | input | PTR_W | Register pointer selecting a mask/base pair |
| inIdx | input | IDX_W | Address index to centrifuge |
| outValid | output | 1 | Result present |
| outReady | input | 1 | Downstream takes the result |
| outTag | output | TAG_W | Physical routing tag |
| outGva | output | GSEG_W+OFF_W | Global segment and segment offset |
| outMiss | output | 1 | Segment lookup found no entry |
| wrEn | input | 1 | Table write strobe |
| wrSel | input | 2 | Write target: 0 mask, 1 base, 2 segment, 3 PE table |
| wrAddr | input | PTR_W | Write address |
| wrData | input | IDX_W | Write data |

## Verification
The bench builds the block with its default parameters, which give:
- a 50-bit index;
- 256 mask/base pairs;
- eight segment entries;
- a 64-entry PE table.

Eight segment entries are enough to program a duplicate virtual segment, for the priority case, and a written-but-invalid entry, for the miss case. The 6-bit PE width lets a base PE plus a virtual PE wrap past 63. The all-ones and all-zeros masks reach both extremes of the centrifuge.

// File: rtl/cx_pkg.sv
package cx_pkg;
  localparam int CX_STAGES = 4;

  typedef enum logic [1:0] {
    WR_MASK = 2'd0,
    WR_BASE = 2'd1,
    WR_SEG  = 2'd2,
    WR_PE   = 2'd3
  } wr_sel_e;

  typedef struct packed {
    logic [CX_STAGES-1:0] load;
    logic wrMask;
    logic wrBase;
    logic wrSeg;
    logic wrPe;
  } strobe_t;
endpackage

// File: rtl/cx_ctrl.sv
module cx_ctrl import cx_pkg::*; (
  input  logic    clk,
  input  logic    rstN,
  input  logic    inValid,
  output logic    inReady,
  output logic    outValid,
  input  logic    outReady,
  input  logic    wrEn,
  input  logic [1:0] wrSel,
  output strobe_t stb
);
  logic [CX_STAGES-1:0] stageVld;
  logic [CX_STAGES-1:0] advance;
  wr_sel_e sel;

  // a stage may load unless it and every stage after it are full and the output is blocked
  generate
    for (genvar g = 0; g < CX_STAGES; g++) begin : g_stage
      assign advance[g] = !((&stageVld[CX_STAGES-1:g]) && !outReady);
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rstN) stageVld[g] <= 1'b0;
          else if (advance[g]) stageVld[g] <= inValid;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rstN) stageVld[g] <= 1'b0;
          else if (advance[g]) stageVld[g] <= stageVld[g-1];
        end
      end
    end
  endgenerate

  assign sel      = wr_sel_e'(wrSel);
  assign inReady  = advance[0];
  assign outValid = stageVld[CX_STAGES-1];

  always_comb begin
    stb.load   = advance;
    stb.wrMask = wrEn && (sel == WR_MASK);
    stb.wrBase = wrEn && (sel == WR_BASE);
    stb.wrSeg  = wrEn && (sel == WR_SEG);
    stb.wrPe   = wrEn && (sel == WR_PE);
  end
endmodule

// File: rtl/cx_datapath.sv
module cx_datapath import cx_pkg::*; #(
  parameter int PTR_W  = 8,
  parameter int IDX_W  = 50,
  parameter int OFF_W  = 32,
  parameter int GSEG_W = 6,
  parameter int PE_W   = 6,
  parameter int TAG_W  = 12,
  parameter int SEG_N  = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  strobe_t                 stb,
  input  logic [PTR_W-1:0]        inPtr,
  input  logic [IDX_W-1:0]        inIdx,
  input  logic [PTR_W-1:0]        wrAddr,
  input  logic [IDX_W-1:0]        wrData,
  output logic [TAG_W-1:0]        outTag,
  output logic [GSEG_W+OFF_W-1:0] outGva,
  output logic                    outMiss
);
  localparam int PTR_N    = 2 ** PTR_W;
  localparam int PE_N     = 2 ** PE_W;
  localparam int VSEG_W   = IDX_W - OFF_W;
  localparam int SEG_AW   = $clog2(SEG_N);
  localparam int CNT_W    = $clog2(IDX_W + 1);
  localparam int F_GSEG   = PE_W;
  localparam int F_VSEG   = PE_W + GSEG_W;
  localparam int F_VALID  = PE_W + GSEG_W + VSEG_W;

  // ---------------- programmable state ----------------
  logic [IDX_W-1:0]  maskMem [PTR_N];
  logic [IDX_W-1:0]  baseMem [PTR_N];
  logic [TAG_W-1:0]  peMem   [PE_N];
  logic              segValid [SEG_N];
  logic [VSEG_W-1:0] segVseg  [SEG_N];
  logic [GSEG_W-1:0] segGseg  [SEG_N];
  logic [PE_W-1:0]   segBpe   [SEG_N];

  always_ff @(posedge clk) begin
    if (stb.wrMask) maskMem[wrAddr] <= wrData;
    if (stb.wrBase) baseMem[wrAddr] <= wrData;
    if (stb.wrPe)   peMem[wrAddr[PE_W-1:0]] <= wrData[TAG_W-1:0];
  end

  generate
    for (genvar g = 0; g < SEG_N; g++) begin : g_seg
      logic hitWr;
      assign hitWr = stb.wrSeg && (wrAddr[SEG_AW-1:0] == SEG_AW'(g));
      always_ff @(posedge clk) begin
        if (!rstN) begin
          segValid[g] <= 1'b0;
        end else if (hitWr) begin
          segValid[g] <= wrData[F_VALID];
          segVseg[g]  <= wrData[F_VSEG +: VSEG_W];
          segGseg[g]  <= wrData[F_GSEG +: GSEG_W];
          segBpe[g]   <= wrData[PE_W-1:0];
        end
      end
    end
  endgenerate

  // ---------------- stage 0: centrifuge ----------------
  logic [IDX_W-1:0] curMask, curBase, gathered, compacted;
  logic [CNT_W-1:0] nOne, nZero;

  assign curMask = maskMem[inPtr];
  assign curBase = baseMem[inPtr];

  always_comb begin
    gathered  = '0;
    compacted = '0;
    nOne      = '0;
    nZero     = '0;
    for (int b = 0; b < IDX_W; b++) begin
      if (curMask[b]) begin
        gathered[nOne] = inIdx[b];
        nOne = nOne + 1'b1;
      end else begin
        compacted[nZero] = inIdx[b];
        nZero = nZero + 1'b1;
      end
    end
  end

  logic [PE_W-1:0]  s0Vpe;
  logic [IDX_W-1:0] s0Off, s0Base;
  always_ff @(posedge clk) begin
    if (stb.load[0]) begin
      s0Vpe  <= gathered[PE_W-1:0];
      s0Off  <= compacted;
      s0Base <= curBase;
    end
  end

  // ---------------- stage 1: base add ----------------
  logic [PE_W-1:0]  s1Vpe;
  logic [IDX_W-1:0] s1Sum;
  always_ff @(posedge clk) begin
    if (stb.load[1]) begin
      s1Vpe <= s0Vpe;
      s1Sum <= s0Base + s0Off;
    end
  end

  // ---------------- stage 2: segment lookup ----------------
  logic [VSEG_W-1:0] lkVseg;
  logic              lkHit;
  logic [GSEG_W-1:0] lkGseg;
  logic [PE_W-1:0]   lkBpe;

  assign lkVseg = s1Sum[IDX_W-1:OFF_W];

  // scan downward so the lowest matching entry is the last assignment
  always_comb begin
    lkHit  = 1'b0;
    lkGseg = '0;
    lkBpe  = '0;
    for (int e = SEG_N - 1; e >= 0; e--) begin
      if (segValid[e] && (segVseg[e] == lkVseg)) begin
        lkHit  = 1'b1;
        lkGseg = segGseg[e];
        lkBpe  = segBpe[e];
      end
    end
  end

  logic              s2Hit;
  logic [GSEG_W-1:0] s2Gseg;
  logic [PE_W-1:0]   s2Bpe, s2Vpe;
  logic [OFF_W-1:0]  s2Off;
  always_ff @(posedge clk) begin
    if (stb.load[2]) begin
      s2Hit  <= lkHit;
      s2Gseg <= lkGseg;
      s2Bpe  <= lkBpe;
      s2Vpe  <= s1Vpe;
      s2Off  <= s1Sum[OFF_W-1:0];
    end
  end

  // ---------------- stage 3: logical PE and tag ----------------
  logic [PE_W-1:0] logicalPe;
  assign logicalPe = s2Bpe + s2Vpe;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outTag  <= '0;
      outGva  <= '0;
      outMiss <= 1'b0;
    end else if (stb.load[3]) begin
      outTag  <= s2Hit ? peMem[logicalPe] : '0;
      outGva  <= {(s2Hit ? s2Gseg : GSEG_W'(0)), s2Off};
      outMiss <= !s2Hit;
    end
  end
endmodule

// File: rtl/centrifuge_xlate.sv
module centrifuge_xlate import cx_pkg::*; #(
  parameter int PTR_W  = 8,
  parameter int IDX_W  = 50,
  parameter int OFF_W  = 32,
  parameter int GSEG_W = 6,
  parameter int PE_W   = 6,
  parameter int TAG_W  = 12,
  parameter int SEG_N  = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  output logic                    inReady,
  input  logic [PTR_W-1:0]        inPtr,
  input  logic [IDX_W-1:0]        inIdx,
  output logic                    outValid,
  input  logic                    outReady,
  output logic [TAG_W-1:0]        outTag,
  output logic [GSEG_W+OFF_W-1:0] outGva,
  output logic                    outMiss,
  input  logic                    wrEn,
  input  logic [1:0]              wrSel,
  input  logic [PTR_W-1:0]        wrAddr,
  input  logic [IDX_W-1:0]        wrData
);
  strobe_t stb;

  cx_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inReady  (inReady),
    .outValid (outValid),
    .outReady (outReady),
    .wrEn     (wrEn),
    .wrSel    (wrSel),
    .stb      (stb)
  );

  cx_datapath #(
    .PTR_W(PTR_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .GSEG_W(GSEG_W),
    .PE_W(PE_W), .TAG_W(TAG_W), .SEG_N(SEG_N)
  ) i_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .inPtr   (inPtr),
    .inIdx   (inIdx),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .outTag  (outTag),
    .outGva  (outGva),
    .outMiss (outMiss)
  );
endmodule

// File: rtl/cx_checker.sv
module cx_checker #(
  parameter int TAG_W  = 12,
  parameter int GVA_W  = 38,
  parameter int GSEG_W = 6
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic             inReady,
  input logic             outValid,
  input logic             outReady,
  input logic [TAG_W-1:0] outTag,
  input logic [GVA_W-1:0] outGva,
  input logic             outMiss
);
  logic [3:0] inFlight;
  always_ff @(posedge clk) begin
    if (!rstN) inFlight <= '0;
    else inFlight <= inFlight + 4'((inValid && inReady) ? 1 : 0) - 4'((outValid && outReady) ? 1 : 0);
  end

  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outTag) && $stable(outGva) && $stable(outMiss)));

  // R5
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outMiss) |-> (outTag == '0 && outGva[GVA_W-1:GVA_W-GSEG_W] == '0));

  // R9
  inflight_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    inFlight <= 4'd4);

  // R8
  stall_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inReady |-> (outValid && !outReady));

  // R9
  out_has_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (inFlight != 4'd0));

  // R10
  reset_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!outValid && inReady));
endmodule

bind centrifuge_xlate cx_checker #(
  .TAG_W(TAG_W), .GVA_W(GSEG_W + OFF_W), .GSEG_W(GSEG_W)
) i_cx_checker (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
  .outValid(outValid), .outReady(outReady), .outTag(outTag),
  .outGva(outGva), .outMiss(outMiss)
);

// File: tb/test_centrifuge_xlate.sv
module test_centrifuge_xlate;
  localparam int IDX_W = 50, OFF_W = 32, GSEG_W = 6, PE_W = 6, TAG_W = 12, SEG_N = 8;
  localparam int VSEG_W = IDX_W - OFF_W;

  logic clk = 0, rstN = 0;
  logic inValid = 0, inReady, outValid, outReady = 0, outMiss;
  logic [7:0] inPtr = '0, wrAddr = '0;
  logic [IDX_W-1:0] inIdx = '0, wrData = '0;
  logic [TAG_W-1:0] outTag;
  logic [GSEG_W+OFF_W-1:0] outGva;
  logic wrEn = 0;
  logic [1:0] wrSel = '0;

  centrifuge_xlate i_centrifuge_xlate (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inPtr(inPtr),
    .inIdx(inIdx), .outValid(outValid), .outReady(outReady), .outTag(outTag),
    .outGva(outGva), .outMiss(outMiss), .wrEn(wrEn), .wrSel(wrSel),
    .wrAddr(wrAddr), .wrData(wrData)
  );

  always #5 clk = ~clk;

  int checks = 0, errs = 0;
  // bench-side model of the programmed tables
  logic [IDX_W-1:0] mMask [256];
  logic [IDX_W-1:0] mBase [256];
  logic mSegV [SEG_N];
  logic [VSEG_W-1:0] mSegVs [SEG_N];
  logic [GSEG_W-1:0] mSegG [SEG_N];
  logic [PE_W-1:0] mSegB [SEG_N];
  logic [TAG_W-1:0] mTag [64];

  logic [7:0] reqPtr [$];
  logic [IDX_W-1:0] reqIdx [$];
  logic [TAG_W-1:0] qTag [$];
  logic [GSEG_W+OFF_W-1:0] qGva [$];
  logic qMiss [$];

  logic pend = 0;
  int cyc = 0, accCnt = 0, stallCnt = 0, outCnt = 0, firstOut = 0, lastOut = 0;

  task automatic check(input logic ok, input string msg);
    checks++;
    if (!ok) begin errs++; $display("FAIL %s", msg); end
  endtask

  function automatic void model(input logic [7:0] p, input logic [IDX_W-1:0] idx,
      output logic [TAG_W-1:0] t, output logic [GSEG_W+OFF_W-1:0] g, output logic m);
    logic [IDX_W-1:0] gat, pk, sum;
    int a, z;
    logic hit;
    logic [GSEG_W-1:0] gs;
    logic [PE_W-1:0] bp, lpe;
    gat = '0; pk = '0; a = 0; z = 0;
    for (int b = 0; b < IDX_W; b++) begin
      if (mMask[p][b]) begin gat[a] = idx[b]; a++; end
      else begin pk[z] = idx[b]; z++; end
    end
    sum = mBase[p] + pk;
    hit = 0; gs = '0; bp = '0;
    for (int e = 0; e < SEG_N; e++)
      if (!hit && mSegV[e] && mSegVs[e] == sum[IDX_W-1:OFF_W]) begin
        hit = 1; gs = mSegG[e]; bp = mSegB[e];
      end
    lpe = bp + gat[PE_W-1:0];
    t = hit ? mTag[lpe] : '0;
    g = {(hit ? gs : GSEG_W'(0)), sum[OFF_W-1:0]};
    m = !hit;
  endfunction

  task automatic doWrite(input logic [1:0] s, input logic [7:0] a, input logic [IDX_W-1:0] d);
    @(negedge clk); wrEn = 1; wrSel = s; wrAddr = a; wrData = d;
    @(negedge clk); wrEn = 0;
  endtask

  task automatic setPtr(input logic [7:0] p, input logic [IDX_W-1:0] mk, input logic [IDX_W-1:0] bs);
    mMask[p] = mk; mBase[p] = bs;
    doWrite(2'd0, p, mk);
    doWrite(2'd1, p, bs);
  endtask

  task automatic setSeg(input int e, input logic v, input logic [VSEG_W-1:0] vs,
      input logic [GSEG_W-1:0] gs, input logic [PE_W-1:0] bp);
    mSegV[e] = v; mSegVs[e] = vs; mSegG[e] = gs; mSegB[e] = bp;
    doWrite(2'd2, 8'(e), IDX_W'({v, vs, gs, bp}));
  endtask

  task automatic addReq(input logic [7:0] p, input logic [IDX_W-1:0] idx);
    reqPtr.push_back(p); reqIdx.push_back(idx);
  endtask

  // one cycle of traffic: drive at negedge, sample handshakes just after
  task automatic step(input int inPct, input int rdyPct);
    logic [TAG_W-1:0] et, t;
    logic [GSEG_W+OFF_W-1:0] eg;
    logic em;
    @(negedge clk); cyc++;
    if (!inValid || pend) begin
      if (reqPtr.size() != 0 && int'($urandom % 100) < inPct) begin
        inPtr = reqPtr.pop_front(); inIdx = reqIdx.pop_front(); inValid = 1;
      end else inValid = 0;
    end
    outReady = int'($urandom % 100) < rdyPct;
    #1;
    if (inValid && !inReady) stallCnt++;
    if (outValid && outReady) begin
      if (outCnt == 0) firstOut = cyc;
      lastOut = cyc; outCnt++;
      if (qMiss.size() == 0) check(0, "R9 unexpected output");
      else begin
        et = qTag.pop_front(); eg = qGva.pop_front(); em = qMiss.pop_front();
        t = outTag;
        // R1 R2 R3 R4 R5 R6: full translation result
        checks++;
        if (t !== et || outGva !== eg || outMiss !== em) begin
          errs++;
          $display("FAIL R1 R2 R3 R4 R5 R6 result: tag=%h gva=%h miss=%b expected tag=%h gva=%h miss=%b",
                   t, outGva, outMiss, et, eg, em);
        end
      end
    end
    pend = inValid && inReady;
    if (pend) begin
      model(inPtr, inIdx, et, eg, em);
      qTag.push_back(et); qGva.push_back(eg); qMiss.push_back(em);
      accCnt++;
    end
  endtask

  task automatic runStream(input int inPct, input int rdyPct);
    int guard = 0;
    while ((reqPtr.size() != 0 || inValid || qMiss.size() != 0) && guard < 20000) begin
      step(inPct, rdyPct); guard++;
    end
    check(guard < 20000, "R9 stream drained");
  endtask

  initial begin
    #(10 * 100000);
    errs++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [TAG_W-1:0] et, holdTag;
    logic [GSEG_W+OFF_W-1:0] eg, holdGva;
    logic em, holdMiss;
    int k;
    void'($urandom(32'd757));
    for (int e = 0; e < SEG_N; e++) mSegV[e] = 0;
    for (int p = 0; p < 256; p++) begin mMask[p] = '0; mBase[p] = '0; end

    repeat (3) @(negedge clk);
    rstN = 1;
    #1;
    // R10 reset state
    check(outValid == 0, $sformatf("R10 outValid after reset act=%b exp=0", outValid));
    check(inReady == 1, $sformatf("R10 inReady after reset act=%b exp=1", inReady));

    // PE table with tags whose low bits name the logical PE (R7 field positions)
    for (int i = 0; i < 64; i++) begin
      mTag[i] = {6'($urandom), 6'(i)};
      doWrite(2'd3, 8'(i), IDX_W'(mTag[i]));
    end
    setPtr(8'd1, {IDX_W{1'b1}}, {18'd2, 32'h0000_1000});   // all ones: R1
    setPtr(8'd0, '0, {18'd0, 32'h0000_0010});              // all zeros: R2
    setPtr(8'd2, {IDX_W{1'b1}}, {18'd3, 32'h0000_0020});   // hits invalid entry 3
    setPtr(8'd3, {IDX_W{1'b1}}, {18'd5, 32'h0000_0040});   // wrap entry 5
    for (int p = 4; p < 8; p++)
      setPtr(8'(p * 31), {18'h3ffff, 32'($urandom)}, {18'($urandom % 10), 32'($urandom)});

    // R10: segment table starts invalid, so a lookup misses
    addReq(8'd1, 50'h3f);
    runStream(100, 100);

    // R7 segment programming; entry 7 duplicates vseg 2 (R4 priority), entry 3 invalid
    for (int e = 0; e < 7; e++) setSeg(e, e != 3, 18'(e), 6'($urandom), 6'($urandom));
    setSeg(5, 1, 18'd5, 6'h2a, 6'd60);
    setSeg(7, 1, 18'd2, 6'h3f, 6'd1);

    // R8 latency
    @(negedge clk); inPtr = 8'd1; inIdx = 50'h15; inValid = 1; outReady = 1;
    model(8'd1, 50'h15, et, eg, em);
    k = 0;
    do begin @(negedge clk); inValid = 0; k++; #1; end while (!outValid && k < 10);
    check(k == 4, $sformatf("R8 latency act=%0d exp=4", k));
    check(outTag == et && outGva == eg && outMiss == em,
          $sformatf("R4 R6 lone result tag=%h gva=%h exp tag=%h gva=%h", outTag, outGva, et, eg));
    @(negedge clk); #1;
    check(outValid == 0, $sformatf("R9 single result not repeated act=%b exp=0", outValid));

    // directed corners: R1 all-ones mask, R2 zero mask, R4 priority, R5 invalid entry, R6 wrap
    addReq(8'd1, 50'h2_0000_0007);
    addReq(8'd0, 50'h0_1234_5678);
    addReq(8'd0, 50'h3_ffff_ffff_ffff);
    addReq(8'd2, 50'h11);
    addReq(8'd3, 50'h3f);
    addReq(8'd3, 50'h0c);
    runStream(100, 100);

    // R8 throughput: 8 back-to-back with the output always ready
    stallCnt = 0; outCnt = 0;
    for (int i = 0; i < 8; i++) addReq(8'(31 * (4 + i % 4)), IDX_W'({$urandom, $urandom}));
    runStream(100, 100);
    check(stallCnt == 0, $sformatf("R8 stalls act=%0d exp=0", stallCnt));
    check(lastOut - firstOut + 1 == 8, $sformatf("R8 output span act=%0d exp=8", lastOut - firstOut + 1));

    // R9 backpressure: only four absorbed, output held
    accCnt = 0;
    for (int i = 0; i < 6; i++) addReq(8'd1, IDX_W'(i * 9));
    for (int i = 0; i < 10; i++) step(100, 0);
    check(accCnt == 4, $sformatf("R9 absorbed act=%0d exp=4", accCnt));
    holdTag = outTag; holdGva = outGva; holdMiss = outMiss;
    check(outValid == 1, $sformatf("R9 outValid while blocked act=%b exp=1", outValid));
    for (int i = 0; i < 3; i++) step(100, 0);
    check(outValid && outTag == holdTag && outGva == holdGva && outMiss == holdMiss,
          $sformatf("R9 held tag=%h gva=%h exp tag=%h gva=%h", outTag, outGva, holdTag, holdGva));
    runStream(100, 100);

    // random traffic with random backpressure
    for (int i = 0; i < 300; i++) begin
      int sel;
      sel = int'($urandom % 6);
      if (sel < 4) addReq(8'(31 * (4 + sel)), IDX_W'({$urandom, $urandom}));
      else if (sel == 4) addReq(8'd1, IDX_W'({$urandom, $urandom}));
      else addReq(8'd0, {17'd0, 33'({$urandom, $urandom})});
    end
    runStream(70, 60);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule